// File: doc/BRIEF.md
# Barrel Shifter for the Second ALU Operand

This block forms the second ALU operand of a 32-bit RISC datapath, together with the shifter carry-out that logical operations later turn into the C flag. It is purely combinational. Both outputs follow the inputs in the same cycle. It picks one of two sources.

The first source is a constant. An 8-bit immediate is rotated right by twice a 4-bit rotate field. The second source is a register value. That value is shifted by one of four shift kinds. The amount comes either from a 5-bit field in the instruction or from the low byte of a second register.

A zero amount given in the instruction field changes meaning. Right shifts then move by a full word, and a rotate becomes a one-bit rotate through the carry. A zero amount taken from a register leaves the operand and the carry as they are. Register amounts of 32 or more each have their own defined result. The carry input is the current C flag.

Top module: `opshift_unit`

## Requirements
- R1: With `use_imm_i`=1, `result_o` is `operand_i[7:0]` zero-extended to 32 bits and rotated right by 2×`amount_i[3:0]`. When that rotate is nonzero, `carry_o` equals `result_o[31]`. `operand_i[31:8]`, `amount_i[7:4]`, `amt_reg_i` and `kind_i` have no effect in this case.
- R2: With `use_imm_i`=1 and `amount_i[3:0]`=0, `result_o` is the zero-extended byte and `carry_o` equals `carry_i`.
- R3: `kind_i` encodes the shift kind: 0 is left logical, 1 is right logical, 2 is right arithmetic and 3 is rotate right. For an amount n from 1 to 31, the shifted-out bit is the carry: `operand_i[32-n]` for the left shift, and `operand_i[n-1]` for the other three kinds.
- R4: With `use_imm_i`=0 and `amt_reg_i`=0, the amount is `amount_i[4:0]` and bits 7:5 are ignored. A left shift by 0 passes the operand unchanged and copies `carry_i` to `carry_o`.
- R5: With `use_imm_i`=0, `amt_reg_i`=0 and an amount field of 0, right logical and right arithmetic shifts behave as a shift by 32.
- R6: With `use_imm_i`=0, `amt_reg_i`=0, an amount field of 0 and kind 3, the result is `{carry_i, operand_i[31:1]}` and `carry_o` is `operand_i[0]`.
- R7: With `use_imm_i`=0, `amt_reg_i`=1 and `amount_i`=0, every kind gives `result_o`=`operand_i` and `carry_o`=`carry_i`.
- R8: A left shift by a register amount of 32 gives 0 with carry `operand_i[0]`. A left shift by more than 32 gives 0 with carry 0.
- R9: A right logical shift by a register amount of 32 gives 0 with carry `operand_i[31]`. By more than 32 it gives 0 with carry 0.
- R10: A right arithmetic shift by a register amount of 32 or more fills every bit with `operand_i[31]`, and `carry_o` is `operand_i[31]`.
- R11: A rotate by a nonzero register amount uses the amount modulo 32. When the amount is a multiple of 32, the operand is unchanged and `carry_o` is `operand_i[31]`.
- R12: The outputs depend only on the present inputs. The block holds no state between cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| use_imm_i | input | 1 | 1 selects the rotated immediate; 0 selects the shifted register operand |
| amt_reg_i | input | 1 | 1 takes the shift amount as a register byte; 0 takes it as a 5-bit instruction field |
| operand_i | input | 32 | Register value, or the immediate in bits 7:0 |
| amount_i | input | 8 | Shift amount (byte or 5-bit field), or the rotate field in bits 3:0 |
| kind_i | input | 2 | Shift kind: 0 left logical, 1 right logical, 2 right arithmetic, 3 rotate right |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Shifted or rotated operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The hardest cases to reach are the register amounts that sit exactly on or just past the word width, such as 32, 33, 64 and 255. The instruction-field zero that changes meaning is just as hard. Uniform random amounts almost never produce these values. The stimulus therefore starts with directed vectors for each boundary. Its random phase then draws amounts from a short list of edge values half of the time. It draws them uniformly from all 256 values for the other half. The expected values come from a model that shifts one bit at a time, which checks the single-step barrel logic independently.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

    localparam int XLEN  = 32;
    localparam int LOG_W = $clog2(XLEN);

    typedef enum logic [1:0] {
        SK_LSL = 2'd0,
        SK_LSR = 2'd1,
        SK_ASR = 2'd2,
        SK_ROR = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic [XLEN-1:0] value;
        logic            carry;
    } shift_res_t;

    // rotate a word right by m places (m taken modulo the word width)
    function automatic logic [XLEN-1:0] ror_word(input logic [XLEN-1:0] x,
                                                  input logic [LOG_W-1:0] m);
        logic [2*XLEN-1:0] dbl;
        dbl = {x, x} >> m;
        return dbl[XLEN-1:0];
    endfunction

endpackage

// File: rtl/opshift_imm_rot.sv
module opshift_imm_rot
    import shifter_pkg::*;
#(
    parameter int IMM_W = 8,
    parameter int ROT_W = 4
) (
    input  logic [IMM_W-1:0] imm,
    input  logic [ROT_W-1:0] rot,
    input  logic             cin,
    output shift_res_t       res
);
    localparam int RAMT_W = ROT_W + 1;

    logic [RAMT_W-1:0] rot_amt;

    always_comb begin
        rot_amt   = {rot, 1'b0};
        res.value = ror_word(XLEN'(imm), LOG_W'(rot_amt));
        res.carry = (rot == '0) ? cin : res.value[XLEN-1];
    end

    // R2
    always_comb begin
        if (rot == '0) begin
            rot0_pass_chk: assert (res.value == XLEN'(imm) && res.carry == cin);
        end
    end

    // R1
    always_comb begin
        imm_popcount_chk: assert ($countones(res.value) == $countones(imm));
    end

endmodule

// File: rtl/opshift_reg_shift.sv
module opshift_reg_shift
    import shifter_pkg::*;
#(
    parameter int AMT_W = 8
) (
    input  logic             amt_reg,
    input  logic [XLEN-1:0]  x,
    input  logic [AMT_W-1:0] amt,
    input  shift_kind_e      kind,
    input  logic             cin,
    output shift_res_t       res
);
    localparam int WIDE = XLEN + 1;

    logic [AMT_W-1:0]        n;
    logic                    zero_field;
    logic [WIDE-1:0]         lsl_w;
    logic [WIDE-1:0]         lsr_w;
    logic signed [WIDE-1:0]  asr_w;
    logic [XLEN-1:0]         ror_v;

    always_comb begin
        zero_field = !amt_reg && (amt[LOG_W-1:0] == '0);
        n = amt_reg ? amt : AMT_W'(amt[LOG_W-1:0]);
        // field value 0 means a full-word move for right shifts
        if (zero_field && (kind == SK_LSR || kind == SK_ASR)) begin
            n = AMT_W'(XLEN);
        end
        lsl_w = {1'b0, x} << n;
        lsr_w = {x, 1'b0} >> n;
        asr_w = $signed({x, 1'b0}) >>> n;
        ror_v = ror_word(x, n[LOG_W-1:0]);

        if (n == '0) begin
            if (zero_field && kind == SK_ROR) begin
                res.value = {cin, x[XLEN-1:1]};
                res.carry = x[0];
            end else begin
                res.value = x;
                res.carry = cin;
            end
        end else begin
            unique case (kind)
                SK_LSL: begin
                    res.value = lsl_w[XLEN-1:0];
                    res.carry = lsl_w[XLEN];
                end
                SK_LSR: begin
                    res.value = lsr_w[XLEN:1];
                    res.carry = lsr_w[0];
                end
                SK_ASR: begin
                    res.value = asr_w[XLEN:1];
                    res.carry = asr_w[0];
                end
                default: begin
                    res.value = ror_v;
                    res.carry = ror_v[XLEN-1];
                end
            endcase
        end
    end

    // R7
    always_comb begin
        if (amt_reg && amt == '0) begin
            reg_zero_hold_chk: assert (res.value == x && res.carry == cin);
        end
    end

    // R10
    always_comb begin
        if (amt_reg && kind == SK_ASR && int'(amt) >= XLEN) begin
            asr_fill_chk: assert ($countones(res.value) == (x[XLEN-1] ? XLEN : 0)
                                  && res.carry == x[XLEN-1]);
        end
    end

    // R8
    always_comb begin
        if (amt_reg && kind == SK_LSL && int'(amt) > XLEN) begin
            lsl_far_chk: assert (res.value == '0 && !res.carry);
        end
    end

    // R6
    always_comb begin
        if (zero_field && kind == SK_ROR) begin
            rrx_chk: assert (res.value[XLEN-2:0] == x[XLEN-1:1]
                             && res.value[XLEN-1] == cin && res.carry == x[0]);
        end
    end

endmodule

// File: rtl/opshift_unit.sv
module opshift_unit
    import shifter_pkg::*;
#(
    parameter int IMM_W = 8,
    parameter int ROT_W = 4,
    parameter int AMT_W = 8
) (
    input  logic             use_imm_i,
    input  logic             amt_reg_i,
    input  logic [XLEN-1:0]  operand_i,
    input  logic [AMT_W-1:0] amount_i,
    input  logic [1:0]       kind_i,
    input  logic             carry_i,
    output logic [XLEN-1:0]  result_o,
    output logic             carry_o
);
    shift_res_t imm_res;
    shift_res_t reg_res;
    shift_res_t sel_res;

    opshift_imm_rot #(.IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
        .imm (operand_i[IMM_W-1:0]),
        .rot (amount_i[ROT_W-1:0]),
        .cin (carry_i),
        .res (imm_res)
    );

    opshift_reg_shift #(.AMT_W(AMT_W)) u_reg (
        .amt_reg (amt_reg_i),
        .x       (operand_i),
        .amt     (amount_i),
        .kind    (shift_kind_e'(kind_i)),
        .cin     (carry_i),
        .res     (reg_res)
    );

    always_comb begin
        sel_res  = use_imm_i ? imm_res : reg_res;
        result_o = sel_res.value;
        carry_o  = sel_res.carry;
    end

    // R1
    always_comb begin
        if (use_imm_i) begin
            imm_high_clear_chk: assert ($countones(result_o) <= IMM_W);
        end
    end

endmodule

// File: tb/opshift_unit_test.sv
module opshift_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        use_imm_i = 1'b0;
    logic        amt_reg_i = 1'b0;
    logic [31:0] operand_i = '0;
    logic [7:0]  amount_i = '0;
    logic [1:0]  kind_i = '0;
    logic        carry_i = 1'b0;
    logic [31:0] result_o;
    logic        carry_o;

    int n_checks = 0;
    int n_miss   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opshift_unit uut (
        .use_imm_i (use_imm_i),
        .amt_reg_i (amt_reg_i),
        .operand_i (operand_i),
        .amount_i  (amount_i),
        .kind_i    (kind_i),
        .carry_i   (carry_i),
        .result_o  (result_o),
        .carry_o   (carry_o)
    );

    // one-bit-at-a-time model: returns {carry, value}
    function automatic logic [32:0] model(logic ui, logic ar, logic [31:0] x,
                                          logic [7:0] a, logic [1:0] k, logic ci);
        logic [31:0] v;
        logic        c;
        int          n;
        c = ci;
        if (ui) begin
            v = {24'h0, x[7:0]};
            for (int i = 0; i < 2 * int'(a[3:0]); i++) begin
                c = v[0];
                v = {v[0], v[31:1]};
            end
            return {c, v};
        end
        v = x;
        n = ar ? int'(a) : int'(a[4:0]);
        if (!ar && n == 0) begin
            if (k == 2'd0) return {ci, x};
            if (k == 2'd3) return {x[0], ci, x[31:1]};
            n = 32;
        end
        for (int i = 0; i < n; i++) begin
            case (k)
                2'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
                2'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
                2'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
                default: begin c = v[0]; v = {v[0], v[31:1]}; end
            endcase
        end
        return {c, v};
    endfunction

    task automatic apply(logic ui, logic ar, logic [31:0] x, logic [7:0] a,
                         logic [1:0] k, logic ci, string tag);
        logic [32:0] exp_v;
        @(posedge clk);
        use_imm_i = ui; amt_reg_i = ar; operand_i = x;
        amount_i = a; kind_i = k; carry_i = ci;
        exp_v = model(ui, ar, x, a, k, ci);
        @(negedge clk);
        n_checks++;
        if (result_o !== exp_v[31:0] || carry_o !== exp_v[32]) begin
            n_miss++;
            $display("FAIL %s: ui=%0b ar=%0b x=%08h a=%0d k=%0d ci=%0b got %08h/%0b expected %08h/%0b",
                     tag, ui, ar, x, a, k, ci, result_o, carry_o, exp_v[31:0], exp_v[32]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_miss++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_miss);
        $finish;
    end

    initial begin
        logic [7:0] edges [8];
        edges = '{8'd0, 8'd1, 8'd31, 8'd32, 8'd33, 8'd64, 8'd96, 8'd255};

        // idle state: all-zero inputs give zero result and zero carry (R12)
        apply(1'b0, 1'b0, 32'h0, 8'h0, 2'd0, 1'b0, "R12 idle");
        // immediate rotate
        apply(1'b1, 1'b0, 32'hFFFF_FF81, 8'hF1, 2'd3, 1'b0, "R1 imm rot2");
        apply(1'b1, 1'b1, 32'h0000_00FF, 8'h04, 2'd0, 1'b0, "R1 imm rot8");
        apply(1'b1, 1'b0, 32'h1234_56A5, 8'h50, 2'd1, 1'b1, "R2 imm rot0 c1");
        apply(1'b1, 1'b0, 32'h0000_0003, 8'h00, 2'd0, 1'b0, "R2 imm rot0 c0");
        // small shifts
        apply(1'b0, 1'b0, 32'h8000_0001, 8'd1,  2'd0, 1'b0, "R3 lsl1");
        apply(1'b0, 1'b0, 32'h8000_0001, 8'd1,  2'd1, 1'b0, "R3 lsr1");
        apply(1'b0, 1'b0, 32'h8000_0010, 8'd5,  2'd2, 1'b0, "R3 asr5");
        apply(1'b0, 1'b1, 32'h0000_0010, 8'd5,  2'd3, 1'b0, "R3 ror5");
        // field zero reinterpretations
        apply(1'b0, 1'b0, 32'hDEAD_BEEF, 8'hE0, 2'd0, 1'b1, "R4 lsl0 upper bits ignored");
        apply(1'b0, 1'b0, 32'h0000_0021, 8'h21, 2'd1, 1'b0, "R4 field uses low five bits");
        apply(1'b0, 1'b0, 32'h8000_0000, 8'd0,  2'd1, 1'b0, "R5 lsr#0");
        apply(1'b0, 1'b0, 32'h8000_0000, 8'd0,  2'd2, 1'b0, "R5 asr#0");
        apply(1'b0, 1'b0, 32'h0000_0003, 8'd0,  2'd3, 1'b1, "R6 rrx");
        apply(1'b0, 1'b0, 32'h0000_0002, 8'd0,  2'd3, 1'b0, "R6 rrx c0");
        // register amounts
        for (int k = 0; k < 4; k++)
            apply(1'b0, 1'b1, 32'h8000_0001, 8'd0, 2'(k), 1'b1, "R7 reg zero");
        apply(1'b0, 1'b1, 32'h0000_0001, 8'd32, 2'd0, 1'b0, "R8 lsl32");
        apply(1'b0, 1'b1, 32'hFFFF_FFFF, 8'd33, 2'd0, 1'b1, "R8 lsl33");
        apply(1'b0, 1'b1, 32'h8000_0000, 8'd32, 2'd1, 1'b0, "R9 lsr32");
        apply(1'b0, 1'b1, 32'hFFFF_FFFF, 8'd200, 2'd1, 1'b1, "R9 lsr200");
        apply(1'b0, 1'b1, 32'h8000_0000, 8'd32, 2'd2, 1'b0, "R10 asr32");
        apply(1'b0, 1'b1, 32'h7FFF_FFFF, 8'd255, 2'd2, 1'b1, "R10 asr255");
        apply(1'b0, 1'b1, 32'h8000_0001, 8'd32, 2'd3, 1'b0, "R11 ror32");
        apply(1'b0, 1'b1, 32'h0000_0001, 8'd64, 2'd3, 1'b1, "R11 ror64");
        apply(1'b0, 1'b1, 32'h0000_0006, 8'd34, 2'd3, 1'b0, "R11 ror34");

        // biased random phase
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a;
            a = ($urandom % 2 == 0) ? edges[$urandom % 8] : 8'($urandom);
            apply(1'($urandom), 1'($urandom), $urandom, a, 2'($urandom),
                  1'($urandom), "R3 R12 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_miss);
        $finish;
    end

endmodule